// File: doc/BRIEF.md
# Display Interface Mode Controller

This block sits between a host register bus, an external video link and the frame-memory write port of a TFT panel driver. It holds the operating mode and decides two things separately. The first is where display timing comes from: an internal oscillator, the external RGB link with its own sync and dot clock, or a mixed mode where the frame starts on the external VSYNC but lines come from the oscillator. The second is who may write the frame memory: the host bus or the pixel bus.

Keeping the two choices apart lets the host rewrite still regions of the memory while a moving picture is shown over the RGB link. The block rejects mode changes that would jump directly between the two external timing modes, and records each rejected attempt in a sticky flag. It freezes the RGB-related settings while RGB timing is active. It tracks the vertical phase of the frame (back porch, display lines, front porch) by counting lines after each frame start. It flags any frame-memory write made under external timing while high-speed write mode is off.

Top module: `disp_mode_ctl`

## Requirements
- R1: After reset, timing_src is 00, ram_src, hsw_required, mode_err, hsw_err and ram_we are 0, and vphase is 0 (back porch).
- R2: A host write to address 0 sets the mode: bits [1:0] give the timing source (00 internal, 01 RGB, 10 VSYNC), bit 2 gives the memory path (1 = pixel bus), bit 3 enables high-speed write. timing_src shows the accepted timing source, and hsw_required is 1 exactly when it is 01 or 10. The code 11 is rejected and sets mode_err.
- R3: ram_src is 1 only while timing is RGB and the path bit is 1. On the host path, a host_ram_we pulse appears one cycle later as ram_we with ram_wdata equal to host_ram_data. On the pixel path, host memory writes are dropped.
- R4: With internal timing, ext_vsync, ext_hsync, ext_dotclk and ext_pixel have no effect. Lines advance on osc_tick, and the frame wraps from the end of the front porch back to the back porch.
- R5: A mode write that requests VSYNC timing while RGB timing is active, or RGB timing while VSYNC timing is active, leaves the timing source unchanged and sets mode_err.
- R6: While RGB timing is active, writes to the line-count registers (address 1 back porch, address 2 display lines, address 3 front porch) are ignored, and so is the path bit of a mode write. The high-speed bit and a change to internal timing are still accepted.
- R7: A rising ext_vsync under RGB or VSYNC timing restarts the frame in the back porch at line 0. Lines are counted on rising ext_hsync under RGB timing and on osc_tick otherwise. The frame runs through the programmed back-porch, display and front-porch line counts, and then stays in the front porch until the next frame start. vphase is 0 for back porch, 1 for display and 2 for front porch. A count of 0 acts as 1.
- R8: On the pixel path, a rising ext_dotclk during a display line samples ext_pixel, which appears on ram_wdata with ram_we one cycle later. Dot clocks during porch lines produce no write.
- R9: hsw_err is set, and stays set, when a memory write is forwarded under RGB or VSYNC timing while the high-speed bit is 0. No such write occurs under internal timing.
- R10: A host write to address 4 clears mode_err when bit 0 is 1 and clears hsw_err when bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | CNT_W | Host register write data |
| host_ram_we | input | 1 | Host frame-memory write strobe |
| host_ram_data | input | PIX_W | Host frame-memory write data |
| ext_vsync | input | 1 | External frame sync |
| ext_hsync | input | 1 | External line sync |
| ext_dotclk | input | 1 | External dot clock, sampled by clk |
| ext_pixel | input | PIX_W | External pixel bus |
| osc_tick | input | 1 | Internal oscillator line tick |
| timing_src | output | 2 | Accepted timing source |
| ram_src | output | 1 | Frame-memory write path, 1 = pixel bus |
| hsw_required | output | 1 | High-speed write mode required |
| vphase | output | 2 | Vertical phase of current line |
| ram_we | output | 1 | Frame-memory write strobe |
| ram_wdata | output | PIX_W | Frame-memory write data |
| mode_err | output | 1 | Sticky rejected-mode flag |
| hsw_err | output | 1 | Sticky write-without-high-speed flag |

## Verification
The bench builds the block with its defaults, an 18-bit pixel bus and 8-bit line counts. It programs porches of one to three lines, so that each vertical phase, the hold in the front porch and the wrap under internal timing are all reached within a handful of sync pulses. A count of zero is programmed to exercise the one-line minimum. Every frame-memory write is predicted into a scoreboard queue, so dropped host writes and dot clocks that arrive during the porches show up as unexpected writes.

// File: rtl/disp_mode_ctl.sv
module disp_mode_ctl #(
  parameter int PIX_W = 18,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [CNT_W-1:0] host_wdata,
  input  logic             host_ram_we,
  input  logic [PIX_W-1:0] host_ram_data,
  input  logic             ext_vsync,
  input  logic             ext_hsync,
  input  logic             ext_dotclk,
  input  logic [PIX_W-1:0] ext_pixel,
  input  logic             osc_tick,
  output logic [1:0]       timing_src,
  output logic             ram_src,
  output logic             hsw_required,
  output logic [1:0]       vphase,
  output logic             ram_we,
  output logic [PIX_W-1:0] ram_wdata,
  output logic             mode_err,
  output logic             hsw_err
);
  localparam logic [1:0] DM_INT = 2'd0, DM_RGB = 2'd1, DM_VSY = 2'd2;
  localparam logic [1:0] PH_BP = 2'd0, PH_DISP = 2'd1, PH_FP = 2'd2;

  logic [1:0]       dm_q, vphase_q;
  logic             rm_q, hwm_q, vs_d, hs_d, dc_d;
  logic [CNT_W-1:0] bp_q, nl_q, fp_q, line_cnt, phase_len;
  logic             ram_we_q, mode_err_q, hsw_err_q;
  logic [PIX_W-1:0] ram_wdata_q;

  wire ext_on   = dm_q != DM_INT;
  wire rgb_on   = dm_q == DM_RGB;
  wire vs_rise  = ext_on & ext_vsync & ~vs_d;
  wire hs_rise  = rgb_on & ext_hsync & ~hs_d;
  wire dc_rise  = rgb_on & ext_dotclk & ~dc_d;
  wire line_tick = rgb_on ? hs_rise : osc_tick;
  wire pix_path = rgb_on & rm_q;

  wire       wr_mode = host_we && host_addr == 3'd0;
  wire       wr_stat = host_we && host_addr == 3'd4;
  wire [1:0] req_dm  = host_wdata[1:0];
  wire       dm_bad  = (req_dm == 2'b11) ||
                       (dm_q == DM_RGB && req_dm == DM_VSY) ||
                       (dm_q == DM_VSY && req_dm == DM_RGB);

  wire             fwd_we   = pix_path ? (dc_rise && vphase_q == PH_DISP) : host_ram_we;
  wire [PIX_W-1:0] fwd_data = pix_path ? ext_pixel : host_ram_data;

  always_comb begin
    case (vphase_q)
      PH_BP:   phase_len = bp_q;
      PH_DISP: phase_len = nl_q;
      default: phase_len = fp_q;
    endcase
  end

  wire [CNT_W:0] cnt_nxt = {1'b0, line_cnt} + {{CNT_W{1'b0}}, 1'b1};
  wire           last    = cnt_nxt >= {1'b0, phase_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_d <= 1'b0;
      hs_d <= 1'b0;
      dc_d <= 1'b0;
    end else begin
      vs_d <= ext_vsync;
      hs_d <= ext_hsync;
      dc_d <= ext_dotclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dm_q  <= DM_INT;
      rm_q  <= 1'b0;
      hwm_q <= 1'b0;
    end else if (wr_mode) begin
      hwm_q <= host_wdata[3];
      if (!dm_bad) dm_q <= req_dm;
      if (!rgb_on) rm_q <= host_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      nl_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      fp_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (host_we && !rgb_on) begin
      if (host_addr == 3'd1) bp_q <= host_wdata;
      if (host_addr == 3'd2) nl_q <= host_wdata;
      if (host_addr == 3'd3) fp_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vphase_q <= PH_BP;
      line_cnt <= '0;
    end else if (vs_rise) begin
      vphase_q <= PH_BP;
      line_cnt <= '0;
    end else if (line_tick) begin
      if (last) begin
        line_cnt <= '0;
        case (vphase_q)
          PH_BP:   vphase_q <= PH_DISP;
          PH_DISP: vphase_q <= PH_FP;
          default: vphase_q <= ext_on ? PH_FP : PH_BP;
        endcase
      end else begin
        line_cnt <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we_q    <= 1'b0;
      ram_wdata_q <= '0;
    end else begin
      ram_we_q <= fwd_we;
      if (fwd_we) ram_wdata_q <= fwd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_err_q <= 1'b0;
      hsw_err_q  <= 1'b0;
    end else begin
      if (wr_mode && dm_bad)              mode_err_q <= 1'b1;
      else if (wr_stat && host_wdata[0])  mode_err_q <= 1'b0;
      if (fwd_we && ext_on && !hwm_q)     hsw_err_q  <= 1'b1;
      else if (wr_stat && host_wdata[1])  hsw_err_q  <= 1'b0;
    end
  end

  assign timing_src   = dm_q;
  assign ram_src      = pix_path;
  assign hsw_required = ext_on;
  assign vphase       = vphase_q;
  assign ram_we       = ram_we_q;
  assign ram_wdata    = ram_wdata_q;
  assign mode_err     = mode_err_q;
  assign hsw_err      = hsw_err_q;

  // R2
  no_reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_q != 2'b11);

  // R5
  no_rgb_to_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_q == DM_RGB) |=> (dm_q != DM_VSY));

  // R5
  no_vsync_to_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_q == DM_VSY) |=> (dm_q != DM_RGB));

  // R6
  rgb_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_q == DM_RGB) |=> ($stable(bp_q) && $stable(nl_q) && $stable(fp_q) && $stable(rm_q)));

  // R8
  porch_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_path && vphase_q != PH_DISP) |=> !ram_we_q);

  // R4
  int_vsync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_q == DM_INT && ext_vsync && !vs_d && !osc_tick) |=> ($stable(vphase_q) && $stable(line_cnt)));

  // R9
  hsw_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsw_err_q) |-> ($past(dm_q) != DM_INT && !$past(hwm_q)));
endmodule

// File: tb/disp_mode_ctl_bench.sv
module disp_mode_ctl_bench;
  localparam int PIX_W = 18;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_we = 1'b0;
  logic [2:0]       host_addr = '0;
  logic [CNT_W-1:0] host_wdata = '0;
  logic             host_ram_we = 1'b0;
  logic [PIX_W-1:0] host_ram_data = '0;
  logic             ext_vsync = 1'b0, ext_hsync = 1'b0, ext_dotclk = 1'b0;
  logic [PIX_W-1:0] ext_pixel = '0;
  logic             osc_tick = 1'b0;
  logic [1:0]       timing_src, vphase;
  logic             ram_src, hsw_required, ram_we, mode_err, hsw_err;
  logic [PIX_W-1:0] ram_wdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [PIX_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  disp_mode_ctl #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_disp_mode_ctl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ram_we(host_ram_we), .host_ram_data(host_ram_data),
    .ext_vsync(ext_vsync), .ext_hsync(ext_hsync), .ext_dotclk(ext_dotclk),
    .ext_pixel(ext_pixel), .osc_tick(osc_tick), .timing_src(timing_src),
    .ram_src(ram_src), .hsw_required(hsw_required), .vphase(vphase),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .mode_err(mode_err), .hsw_err(hsw_err));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && ram_we) begin
      if (exp_q.size() == 0) check("R3/R8 unexpected ram write", 1, 0);
      else check("R3/R8 ram write data", int'(ram_wdata), int'(exp_q.pop_front()));
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_ram(input logic [PIX_W-1:0] d, input bit expect_wr);
    host_ram_we = 1'b1; host_ram_data = d;
    if (expect_wr) exp_q.push_back(d);
    @(negedge clk);
    host_ram_we = 1'b0;
  endtask

  task automatic dot(input logic [PIX_W-1:0] d, input bit expect_wr);
    ext_pixel = d; ext_dotclk = 1'b1;
    if (expect_wr) exp_q.push_back(d);
    @(negedge clk);
    ext_dotclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic hs_pulse();
    ext_hsync = 1'b1; @(negedge clk); ext_hsync = 1'b0; @(negedge clk);
  endtask

  task automatic vs_pulse();
    ext_vsync = 1'b1; @(negedge clk); ext_vsync = 1'b0; @(negedge clk);
  endtask

  task automatic tick();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 timing_src", timing_src, 0);
    check("R1 ram_src", ram_src, 0);
    check("R1 hsw_required", hsw_required, 0);
    check("R1 vphase", vphase, 0);
    check("R1 mode_err", mode_err, 0);
    check("R1 hsw_err", hsw_err, 0);
    check("R1 ram_we", ram_we, 0);

    // R3 host write under internal timing
    host_ram(18'h12345, 1);

    // R4 internal timing: path bit set but host path kept, external inputs ignored
    reg_wr(3'd1, 8'd2); reg_wr(3'd2, 8'd3); reg_wr(3'd3, 8'd1);
    reg_wr(3'd0, 8'h04);
    check("R3 ram_src internal", ram_src, 0);
    vs_pulse(); hs_pulse(); hs_pulse(); hs_pulse();
    dot(18'h3ffff, 0);
    check("R4 vphase unchanged by ext", vphase, 0);
    tick(); tick();
    check("R4 display after osc ticks", vphase, 1);
    tick(); tick(); tick();
    check("R4 front porch", vphase, 2);
    tick();
    check("R4 wrap to back porch", vphase, 0);
    // R9 no error under internal timing
    host_ram(18'h00abc, 1);
    check("R9 hsw_err internal", hsw_err, 0);

    // R2 enter RGB, pixel path, high-speed on
    reg_wr(3'd0, 8'h0d);
    check("R2 timing_src rgb", timing_src, 1);
    check("R2 hsw_required rgb", hsw_required, 1);
    check("R3 ram_src pixel", ram_src, 1);
    host_ram(18'h11111, 0);

    // R7 / R8 RGB line counting and pixel sampling
    vs_pulse();
    check("R7 vsync restart", vphase, 0);
    dot(18'h22222, 0);
    hs_pulse(); hs_pulse();
    check("R7 rgb display", vphase, 1);
    dot(18'h2aaaa, 1);
    dot(18'h15555, 1);
    hs_pulse(); hs_pulse(); hs_pulse();
    check("R7 rgb front porch", vphase, 2);
    hs_pulse(); hs_pulse();
    check("R7 rgb front porch hold", vphase, 2);
    dot(18'h33333, 0);
    check("R9 hsw_err with high-speed on", hsw_err, 0);

    // R6 settings frozen under RGB
    reg_wr(3'd1, 8'd5);
    reg_wr(3'd0, 8'h09);
    check("R6 path bit ignored", ram_src, 1);
    vs_pulse(); hs_pulse(); hs_pulse();
    check("R6 porch write ignored", vphase, 1);

    // R5 RGB to VSYNC rejected
    reg_wr(3'd0, 8'h0a);
    check("R5 rgb kept", timing_src, 1);
    check("R5 mode_err set", mode_err, 1);
    reg_wr(3'd4, 8'h01);
    check("R10 mode_err cleared", mode_err, 0);

    // back to internal, reprogram, then VSYNC timing with high-speed off
    reg_wr(3'd0, 8'h08);
    check("R6 leave rgb accepted", timing_src, 0);
    reg_wr(3'd1, 8'd1); reg_wr(3'd2, 8'd0); reg_wr(3'd3, 8'd2);
    reg_wr(3'd0, 8'h02);
    check("R2 timing_src vsync", timing_src, 2);
    check("R2 hsw_required vsync", hsw_required, 1);
    check("R3 ram_src vsync", ram_src, 0);
    reg_wr(3'd0, 8'h01);
    check("R5 vsync kept", timing_src, 2);
    check("R5 mode_err from vsync", mode_err, 1);
    reg_wr(3'd4, 8'h01);

    // R7 VSYNC timing: frame on vsync, lines on osc, zero count acts as one
    vs_pulse();
    check("R7 vsync mode restart", vphase, 0);
    hs_pulse();
    check("R7 hsync ignored in vsync mode", vphase, 0);
    tick();
    check("R7 vsync mode display", vphase, 1);
    tick();
    check("R7 zero count one line", vphase, 2);
    tick(); tick(); tick();
    check("R7 vsync mode front hold", vphase, 2);

    // R9 write without high-speed under VSYNC timing
    host_ram(18'h0beef, 1);
    check("R9 hsw_err set", hsw_err, 1);
    reg_wr(3'd4, 8'h02);
    check("R10 hsw_err cleared", hsw_err, 0);

    // R2 reserved code rejected
    reg_wr(3'd0, 8'h03);
    check("R2 reserved rejected", timing_src, 2);
    check("R2 reserved sets mode_err", mode_err, 1);

    repeat (2) @(negedge clk);
    check("R3/R8 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule